// File: doc/BRIEF.md
# Private Interrupt Register Bank with Secure Banking

This block holds the per-CPU configuration and state of 32 private interrupts. Numbers 0 to 15 are software-generated and numbers 16 to 31 are peripheral. A processor reaches it over a simple memory-mapped port. Every access carries a secure attribute, and accesses are one byte or one 32-bit word wide. The block also watches 16 peripheral level inputs and a software-generated interrupt request channel. It updates its pending state from both.

Security filtering is the central idea. A global `sec_disable` input turns the filtering off. While security is on, a non-secure access sees only the interrupts whose group bit is 1. Every set, clear and read is masked bit by bit with the group register. Priorities seen from the non-secure side are shown shifted by one bit and forced into the upper half of the range.

The bank only stores and filters state. Choosing the winning interrupt is left to logic downstream, which reads the effective pending and enable vectors.

Top module: `prv_irq_regbank`

Register map (byte offsets, word accesses unless noted):

| Offset | Name | Notes |
|---|---|---|
| 0x00 | WAKE | bit0 is the sleep request; bit1 reads as a copy of bit0 |
| 0x04 | GROUP | bit n is the group of interrupt n |
| 0x08 / 0x0C | ENABLE set / clear | |
| 0x10 / 0x14 | PEND set / clear | |
| 0x18 / 0x1C | ACTIVE set / clear | |
| 0x20 / 0x24 | CFG_LO / CFG_HI | edge flag of interrupt n at bit 2(n mod 16)+1 |
| 0x28 | GMOD | group modifier |
| 0x2C | NSAC | non-secure access field of SGI n at bits 2n+1:2n |
| 0x40–0x5F | PRIO | one byte per interrupt; byte or word access |

## Requirements
- R1: After reset all stored state is zero. A secure read returns 0 from GROUP, ENABLE, PEND, ACTIVE, GMOD, NSAC, WAKE and PRIO, and 0xAAAAAAAA from CFG_LO.
- R2: The access mask is GROUP when the access is non-secure and `sec_disable` is 0; otherwise it is all ones. A set alias ORs in `wdata & mask`. A clear alias clears the bits of `wdata & mask`. Reads of ENABLE, PEND and ACTIVE return the value ANDed with the mask.
- R3: GROUP reads 0 and ignores writes for a non-secure access while `sec_disable` is 0. GMOD and NSAC read 0 and ignore writes unless the access is secure and `sec_disable` is 0.
- R4: Take a non-secure access with `sec_disable` 0. If the interrupt's group bit is 1, a priority read returns `(stored << 1) & 0xFF` and a write stores `0x80 | (value >> 1)`. If the group bit is 0, the read returns 0 and the write is ignored. Secure accesses see the raw byte.
- R5: A word access to PRIO at offset 0x40+4k covers interrupts 4k to 4k+3, with interrupt 4k in bits 7:0. A byte access at 0x40+n reaches interrupt n alone and returns its view in bits 7:0.
- R6: A PEND read returns the pending latch ORed with the live `ppi_level` of every peripheral interrupt configured level-triggered. A level-triggered input does not latch.
- R7: Software-generated interrupts are always edge-triggered. A CFG read returns the masked edge flags at odd bit positions and zeros at even positions. Writes to CFG_LO are ignored. A CFG_HI write takes bit 2m+1 as the edge flag of interrupt 16+m and updates only masked bits.
- R8: Only WAKE bit0 is writable. Bit1 reads back equal to bit0 immediately, and all other bits read 0.
- R9: A 0-to-1 change on `ppi_level[m]` sets the pending latch of interrupt 16+m only when that interrupt is edge-triggered. An unchanged level sets nothing.
- R10: The resolved group of an SGI is 2 (non-secure group 1) when its GROUP bit is 1. Otherwise it is 1 (secure group 1) when GMOD is set and `sec_disable` is 0, and 0 otherwise. A request with `sgi_grp`=1 is taken as 0 when the resolved group is 0. A request is dropped if its group does not match the resolved group.
- R11: Take a request with `sgi_ns`=1 while `sec_disable` is 0. For a resolved group 0 the NSAC field of that SGI must be at least 1, and for resolved group 1 at least 2; otherwise the request is dropped. An accepted request sets the SGI's pending latch.
- R12: A word access to an unmapped offset, or a byte access outside PRIO, completes and reads 0. It has no effect when written.
- R13: A bus write, an input edge or an accepted SGI request is visible from the clock edge that samples it. A PEND read one cycle earlier still shows the old latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | access strobe, one cycle per access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | 1 byte access, 0 word access |
| bus_secure | input | 1 | secure attribute of the access |
| bus_addr | input | ADDR_W | byte offset |
| bus_wdata | input | 32 | write data; byte writes use bits 7:0 |
| bus_rdata | output | 32 | read data, valid in the cycle of the read |
| sec_disable | input | 1 | 1 turns off security filtering |
| ppi_level | input | NUM_PPI | peripheral interrupt levels |
| sgi_req | input | 1 | software-generated interrupt request strobe |
| sgi_id | input | log2(NUM_SGI) | target SGI number |
| sgi_grp | input | 2 | requested group: 0, 1 secure, 2 non-secure |
| sgi_ns | input | 1 | request comes from the non-secure side |
| pend_vec | output | NUM_IRQ | effective pending (latch OR live level) |
| enable_vec | output | NUM_IRQ | enable bitmap |

## Verification
The random traffic mixes secure and non-secure accesses, toggles `sec_disable` and varies the group bits. Because of this, a mask applied in the wrong place shows up as a wrong bitmap or a wrong priority view. Peripheral inputs change at random under mixed edge and level settings. Reads of PEND then separate the latched state from the live level term. Directed cases cover the following: the byte order of priority words, the shifted non-secure priority view, CFG_LO being read-only, each branch of SGI group resolution and the NSAC threshold, and the one-cycle delay from an input edge to the pending latch.

// File: rtl/prvirq_pkg.sv
package prvirq_pkg;

  localparam int unsigned PRIO_W = 8;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2
  } grp_e;

  localparam logic [7:0] OFS_WAKE   = 8'h00;
  localparam logic [7:0] OFS_GROUP  = 8'h04;
  localparam logic [7:0] OFS_EN_SET = 8'h08;
  localparam logic [7:0] OFS_EN_CLR = 8'h0C;
  localparam logic [7:0] OFS_PD_SET = 8'h10;
  localparam logic [7:0] OFS_PD_CLR = 8'h14;
  localparam logic [7:0] OFS_AC_SET = 8'h18;
  localparam logic [7:0] OFS_AC_CLR = 8'h1C;
  localparam logic [7:0] OFS_CFG_LO = 8'h20;
  localparam logic [7:0] OFS_CFG_HI = 8'h24;
  localparam logic [7:0] OFS_GMOD   = 8'h28;
  localparam logic [7:0] OFS_NSAC   = 8'h2C;
  localparam logic [7:0] OFS_PRIO   = 8'h40;

  // Non-secure view of a stored priority byte
  function automatic logic [PRIO_W-1:0] prio_ns_view(input logic [PRIO_W-1:0] raw);
    return {raw[PRIO_W-2:0], 1'b0};
  endfunction

  // Value stored when the non-secure side writes a priority byte
  function automatic logic [PRIO_W-1:0] prio_ns_store(input logic [PRIO_W-1:0] v);
    return {1'b1, v[PRIO_W-1:1]};
  endfunction

endpackage

// File: rtl/prvirq_prio_bank.sv
module prvirq_prio_bank
  import prvirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        wr_en,
  input  logic [NUM_IRQ*PRIO_W-1:0] wr_data,
  input  logic                      ns_lim,
  input  logic [NUM_IRQ-1:0]        grp,
  output logic [NUM_IRQ*PRIO_W-1:0] rd_view
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
    logic [PRIO_W-1:0] prio_q, prio_d;
    logic              lane_en;

    assign lane_en = wr_en[i] & (~ns_lim | grp[i]);

    always_comb begin
      prio_d = ns_lim ? prio_ns_store(wr_data[i*PRIO_W +: PRIO_W])
                      : wr_data[i*PRIO_W +: PRIO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prio_q <= '0;
      else if (lane_en) prio_q <= prio_d;
    end

    assign rd_view[i*PRIO_W +: PRIO_W] = !ns_lim ? prio_q :
                                         (grp[i] ? prio_ns_view(prio_q) : '0);
  end

endmodule

// File: rtl/prvirq_ppi_edge.sv
module prvirq_ppi_edge #(
  parameter int unsigned NUM_PPI = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_PPI-1:0] level,
  input  logic [NUM_PPI-1:0] edge_cfg,
  output logic [NUM_PPI-1:0] set_vec
);

  logic [NUM_PPI-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  assign set_vec = level & ~level_q & edge_cfg;

endmodule

// File: rtl/prvirq_sgi_gate.sv
module prvirq_sgi_gate
  import prvirq_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  localparam int unsigned ID_W   = $clog2(NUM_SGI)
) (
  input  logic                 req,
  input  logic [ID_W-1:0]      id,
  input  logic [1:0]           req_grp,
  input  logic                 ns,
  input  logic                 sec_disable,
  input  logic [NUM_SGI-1:0]   grp_bits,
  input  logic [NUM_SGI-1:0]   mod_bits,
  input  logic [2*NUM_SGI-1:0] nsac,
  output logic [NUM_SGI-1:0]   set_vec
);

  grp_e       irq_grp, eff_grp;
  logic [1:0] field;
  logic       accept;

  always_comb begin
    if (grp_bits[id])                      irq_grp = GRP_G1NS;
    else if (mod_bits[id] && !sec_disable) irq_grp = GRP_G1S;
    else                                   irq_grp = GRP_G0;

    if (grp_e'(req_grp) == GRP_G1S && irq_grp == GRP_G0) eff_grp = GRP_G0;
    else                                                 eff_grp = grp_e'(req_grp);

    field  = nsac[2*id +: 2];
    accept = req && (eff_grp == irq_grp);
    if (ns && !sec_disable) begin
      if (irq_grp == GRP_G0  && field < 2'd1) accept = 1'b0;
      if (irq_grp == GRP_G1S && field < 2'd2) accept = 1'b0;
    end

    set_vec     = '0;
    set_vec[id] = accept;
  end

endmodule

// File: rtl/prv_irq_regbank.sv
module prv_irq_regbank
  import prvirq_pkg::*;
#(
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned NUM_PPI = 16,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int unsigned ID_W    = $clog2(NUM_SGI),
  localparam int unsigned IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_byte,
  input  logic               bus_secure,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               sec_disable,
  input  logic [NUM_PPI-1:0] ppi_level,
  input  logic               sgi_req,
  input  logic [ID_W-1:0]    sgi_id,
  input  logic [1:0]         sgi_grp,
  input  logic               sgi_ns,
  output logic [NUM_IRQ-1:0] pend_vec,
  output logic [NUM_IRQ-1:0] enable_vec
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // stored state
  logic [NUM_IRQ-1:0]   grp_q, en_q, pend_q, act_q, gmod_q;
  logic [NUM_IRQ-1:0]   grp_d, en_d, pend_d, act_d, gmod_d;
  logic [2*NUM_SGI-1:0] nsac_q, nsac_d;
  logic [NUM_PPI-1:0]   edge_q, edge_d;
  logic                 sleep_q, sleep_d;

  // access qualifiers
  logic               wr_acc, rd_acc, ns_lim, sec_only, in_prio;
  logic [NUM_IRQ-1:0] acc_mask;
  logic [ADDR_W-1:0]  prio_ofs;
  logic [IDX_W-1:0]   pidx;

  assign wr_acc   = bus_valid & bus_write;
  assign rd_acc   = bus_valid & ~bus_write;
  assign ns_lim   = ~bus_secure & ~sec_disable;
  assign sec_only = bus_secure & ~sec_disable;
  assign acc_mask = ns_lim ? grp_q : '1;
  assign prio_ofs = bus_addr - ADDR_W'(OFS_PRIO);
  assign in_prio  = (bus_addr >= ADDR_W'(OFS_PRIO)) && (prio_ofs < ADDR_W'(NUM_IRQ));
  assign pidx     = prio_ofs[IDX_W-1:0];

  // priority lanes
  logic [NUM_IRQ-1:0]        prio_we;
  logic [NUM_IRQ*PRIO_W-1:0] prio_wd, prio_view;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pwr
    assign prio_we[i] = wr_acc && in_prio &&
                        (bus_byte ? (pidx == IDX_W'(i))
                                  : (pidx[IDX_W-1:2] == (IDX_W-2)'(i / 4)));
    assign prio_wd[i*PRIO_W +: PRIO_W] = bus_byte ? bus_wdata[PRIO_W-1:0]
                                                  : bus_wdata[(i % 4)*PRIO_W +: PRIO_W];
  end

  prvirq_prio_bank #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (prio_we),
    .wr_data (prio_wd),
    .ns_lim  (ns_lim),
    .grp     (grp_q),
    .rd_view (prio_view)
  );

  // hardware pending sources
  logic [NUM_PPI-1:0] ppi_set;
  logic [NUM_SGI-1:0] sgi_set;

  prvirq_ppi_edge #(.NUM_PPI(NUM_PPI)) u_edge (
    .clk      (clk),
    .rst_n    (srst_n),
    .level    (ppi_level),
    .edge_cfg (edge_q),
    .set_vec  (ppi_set)
  );

  prvirq_sgi_gate #(.NUM_SGI(NUM_SGI)) u_sgi (
    .req         (sgi_req),
    .id          (sgi_id),
    .req_grp     (sgi_grp),
    .ns          (sgi_ns),
    .sec_disable (sec_disable),
    .grp_bits    (grp_q[NUM_SGI-1:0]),
    .mod_bits    (gmod_q[NUM_SGI-1:0]),
    .nsac        (nsac_q),
    .set_vec     (sgi_set)
  );

  // configuration word packing: edge flag at odd positions
  logic [NUM_IRQ-1:0] edge_all, edge_vis;
  logic [31:0]        cfg_lo_rd, cfg_hi_rd;
  logic [NUM_PPI-1:0] cfg_hi_new;

  assign edge_all = {edge_q, {NUM_SGI{1'b1}}};
  assign edge_vis = edge_all & acc_mask;

  for (genvar n = 0; n < NUM_PPI; n++) begin : g_cfg
    assign cfg_lo_rd[2*n]   = 1'b0;
    assign cfg_lo_rd[2*n+1] = edge_vis[n];
    assign cfg_hi_rd[2*n]   = 1'b0;
    assign cfg_hi_rd[2*n+1] = edge_vis[NUM_SGI+n];
    assign cfg_hi_new[n]    = bus_wdata[2*n+1];
  end

  assign pend_vec   = pend_q | {ppi_level & ~edge_q, {NUM_SGI{1'b0}}};
  assign enable_vec = en_q;

  // next state
  logic [NUM_IRQ-1:0] wm;
  assign wm = bus_wdata[NUM_IRQ-1:0] & acc_mask;

  always_comb begin
    grp_d   = grp_q;
    en_d    = en_q;
    act_d   = act_q;
    gmod_d  = gmod_q;
    nsac_d  = nsac_q;
    edge_d  = edge_q;
    sleep_d = sleep_q;
    pend_d  = pend_q;
    if (wr_acc && !bus_byte) begin
      case (bus_addr)
        ADDR_W'(OFS_WAKE):   sleep_d = bus_wdata[0];
        ADDR_W'(OFS_GROUP):  if (!ns_lim) grp_d = bus_wdata[NUM_IRQ-1:0];
        ADDR_W'(OFS_EN_SET): en_d   = en_q | wm;
        ADDR_W'(OFS_EN_CLR): en_d   = en_q & ~wm;
        ADDR_W'(OFS_PD_SET): pend_d = pend_q | wm;
        ADDR_W'(OFS_PD_CLR): pend_d = pend_q & ~wm;
        ADDR_W'(OFS_AC_SET): act_d  = act_q | wm;
        ADDR_W'(OFS_AC_CLR): act_d  = act_q & ~wm;
        ADDR_W'(OFS_CFG_HI): edge_d = (edge_q & ~acc_mask[NUM_IRQ-1:NUM_SGI]) |
                                      (cfg_hi_new & acc_mask[NUM_IRQ-1:NUM_SGI]);
        ADDR_W'(OFS_GMOD):   if (sec_only) gmod_d = bus_wdata[NUM_IRQ-1:0];
        ADDR_W'(OFS_NSAC):   if (sec_only) nsac_d = bus_wdata[2*NUM_SGI-1:0];
        default: ;
      endcase
    end
    // hardware sources win over a clear in the same cycle
    pend_d = pend_d | {ppi_set, sgi_set};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      grp_q   <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      gmod_q  <= '0;
      nsac_q  <= '0;
      edge_q  <= '0;
      sleep_q <= 1'b0;
    end else begin
      grp_q   <= grp_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
      act_q   <= act_d;
      gmod_q  <= gmod_d;
      nsac_q  <= nsac_d;
      edge_q  <= edge_d;
      sleep_q <= sleep_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      if (bus_byte) begin
        if (in_prio) bus_rdata = {24'b0, prio_view[int'(pidx)*PRIO_W +: PRIO_W]};
      end else if (in_prio) begin
        bus_rdata = prio_view[int'({pidx[IDX_W-1:2], 2'b00})*PRIO_W +: 32];
      end else begin
        case (bus_addr)
          ADDR_W'(OFS_WAKE):   bus_rdata = {30'b0, sleep_q, sleep_q};
          ADDR_W'(OFS_GROUP):  bus_rdata = ns_lim ? '0 : grp_q;
          ADDR_W'(OFS_EN_SET),
          ADDR_W'(OFS_EN_CLR): bus_rdata = en_q & acc_mask;
          ADDR_W'(OFS_PD_SET),
          ADDR_W'(OFS_PD_CLR): bus_rdata = pend_vec & acc_mask;
          ADDR_W'(OFS_AC_SET),
          ADDR_W'(OFS_AC_CLR): bus_rdata = act_q & acc_mask;
          ADDR_W'(OFS_CFG_LO): bus_rdata = cfg_lo_rd;
          ADDR_W'(OFS_CFG_HI): bus_rdata = cfg_hi_rd;
          ADDR_W'(OFS_GMOD):   bus_rdata = sec_only ? gmod_q : '0;
          ADDR_W'(OFS_NSAC):   bus_rdata = sec_only ? nsac_q : '0;
          default:             bus_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/prvirq_checker.sv
module prvirq_checker
  import prvirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned NUM_SGI = 16,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               srst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic               bus_byte,
  input logic               bus_secure,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               sec_disable,
  input logic               sgi_req,
  input logic [NUM_IRQ-NUM_SGI-1:0] ppi_level,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_SGI-1:0] sgi_set
);

  logic rd_w, ns_lim, prio_rng;
  assign rd_w     = bus_valid && !bus_write && !bus_byte;
  assign ns_lim   = !bus_secure && !sec_disable;
  assign prio_rng = (bus_addr >= ADDR_W'(OFS_PRIO)) &&
                    (bus_addr <  ADDR_W'(OFS_PRIO) + ADDR_W'(NUM_IRQ));

  AST_GROUP_NS_RAZ: assert property (@(posedge clk) disable iff (!srst_n)
    rd_w && ns_lim && bus_addr == ADDR_W'(OFS_GROUP) |-> bus_rdata == '0); // R3

  AST_SECONLY_RAZ: assert property (@(posedge clk) disable iff (!srst_n)
    rd_w && !(bus_secure && !sec_disable) &&
    (bus_addr == ADDR_W'(OFS_GMOD) || bus_addr == ADDR_W'(OFS_NSAC)) |-> bus_rdata == '0); // R3

  AST_PRIO_NS_LSB: assert property (@(posedge clk) disable iff (!srst_n)
    rd_w && ns_lim && prio_rng |->
      (!bus_rdata[0] && !bus_rdata[8] && !bus_rdata[16] && !bus_rdata[24])); // R4

  AST_CFG_EVEN_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    rd_w && (bus_addr == ADDR_W'(OFS_CFG_LO) || bus_addr == ADDR_W'(OFS_CFG_HI)) |->
      (bus_rdata & 32'h5555_5555) == '0); // R7

  AST_CFG_LO_SGI_EDGE: assert property (@(posedge clk) disable iff (!srst_n)
    rd_w && !ns_lim && bus_addr == ADDR_W'(OFS_CFG_LO) |-> bus_rdata == 32'hAAAA_AAAA); // R7

  AST_WAKE_MIRROR: assert property (@(posedge clk) disable iff (!srst_n)
    rd_w && bus_addr == ADDR_W'(OFS_WAKE) |->
      (bus_rdata[1] == bus_rdata[0]) && (bus_rdata[31:2] == '0)); // R8

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_valid && bus_write) && !sgi_req && $stable(ppi_level) |=> $stable(pend_q)); // R13

  AST_SGI_ONEHOT: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(sgi_set)); // R10

  AST_SGI_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    !sgi_req |-> sgi_set == '0); // R11

  AST_BYTE_OUTSIDE_RAZ: assert property (@(posedge clk) disable iff (!srst_n)
    bus_valid && !bus_write && bus_byte && !prio_rng |-> bus_rdata == '0); // R12

endmodule

bind prv_irq_regbank prvirq_checker #(
  .NUM_IRQ (NUM_IRQ),
  .NUM_SGI (NUM_SGI),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_byte    (bus_byte),
  .bus_secure  (bus_secure),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .sec_disable (sec_disable),
  .sgi_req     (sgi_req),
  .ppi_level   (ppi_level),
  .pend_q      (pend_q),
  .sgi_set     (sgi_set)
);

// File: tb/prv_irq_regbank_tb_top.sv
`timescale 1ns/1ps
module prv_irq_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write, bus_byte, bus_secure;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sec_disable;
  logic [15:0] ppi_level;
  logic        sgi_req, sgi_ns;
  logic [3:0]  sgi_id;
  logic [1:0]  sgi_grp;
  logic [31:0] pend_vec, enable_vec;

  always #2.5 clk = ~clk;

  prv_irq_regbank dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_byte(bus_byte),
    .bus_secure(bus_secure), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sec_disable(sec_disable), .ppi_level(ppi_level),
    .sgi_req(sgi_req), .sgi_id(sgi_id), .sgi_grp(sgi_grp), .sgi_ns(sgi_ns),
    .pend_vec(pend_vec), .enable_vec(enable_vec)
  );

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [31:0] m_grp, m_en, m_pend, m_act, m_mod, m_nsac;
  logic [15:0] m_edge, m_lvl;
  logic        m_sleep;
  logic [7:0]  m_prio [32];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_mask(input bit s);
    return (!s && !sec_disable) ? m_grp : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] spread(input logic [15:0] e);
    logic [31:0] r = '0;
    for (int n = 0; n < 16; n++) r[2*n+1] = e[n];
    return r;
  endfunction

  function automatic logic [7:0] m_pview(input int i, input bit s);
    if (s || sec_disable) return m_prio[i];
    if (!m_grp[i]) return 8'h00;
    return {m_prio[i][6:0], 1'b0};
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a, input bit b, input bit s);
    logic [31:0] mk = m_mask(s);
    bit so = s && !sec_disable;
    if (a >= 8'h40 && a < 8'h60) begin
      if (b) return {24'b0, m_pview(int'(a) - 64, s)};
      return {m_pview(int'({a[7:2], 2'b00}) - 61, s), m_pview(int'({a[7:2], 2'b00}) - 62, s),
              m_pview(int'({a[7:2], 2'b00}) - 63, s), m_pview(int'({a[7:2], 2'b00}) - 64, s)};
    end
    if (b) return '0;
    case (a)
      8'h00: return {30'b0, m_sleep, m_sleep};
      8'h04: return (!s && !sec_disable) ? 32'h0 : m_grp;
      8'h08, 8'h0C: return m_en & mk;
      8'h10, 8'h14: return (m_pend | {m_lvl & ~m_edge, 16'h0}) & mk;
      8'h18, 8'h1C: return m_act & mk;
      8'h20: return spread(16'hFFFF & mk[15:0]);
      8'h24: return spread(m_edge & mk[31:16]);
      8'h28: return so ? m_mod : 32'h0;
      8'h2C: return so ? m_nsac : 32'h0;
      default: return '0;
    endcase
  endfunction

  task automatic m_pwr(input int i, input logic [7:0] v, input bit lim);
    if (!lim) m_prio[i] = v;
    else if (m_grp[i]) m_prio[i] = {1'b1, v[7:1]};
  endtask

  task automatic m_write(input logic [7:0] a, input bit b, input bit s, input logic [31:0] d);
    logic [31:0] mk = m_mask(s);
    bit lim = !s && !sec_disable;
    bit so  = s && !sec_disable;
    if (a >= 8'h40 && a < 8'h60) begin
      if (b) m_pwr(int'(a) - 64, d[7:0], lim);
      else for (int k = 0; k < 4; k++) m_pwr(int'({a[7:2], 2'b00}) - 64 + k, d[k*8 +: 8], lim);
    end else if (!b) begin
      case (a)
        8'h00: m_sleep = d[0];
        8'h04: if (!lim) m_grp = d;
        8'h08: m_en   = m_en | (d & mk);
        8'h0C: m_en   = m_en & ~(d & mk);
        8'h10: m_pend = m_pend | (d & mk);
        8'h14: m_pend = m_pend & ~(d & mk);
        8'h18: m_act  = m_act | (d & mk);
        8'h1C: m_act  = m_act & ~(d & mk);
        8'h24: for (int n = 0; n < 16; n++) if (mk[16+n]) m_edge[n] = d[2*n+1];
        8'h28: if (so) m_mod = d;
        8'h2C: if (so) m_nsac = d;
        default: ;
      endcase
    end
  endtask

  function automatic bit m_sgi_ok(input int id, input int g, input bit ns);
    int irqg, eg;
    logic [1:0] f;
    irqg = m_grp[id] ? 2 : ((m_mod[id] && !sec_disable) ? 1 : 0);
    eg = (g == 1 && irqg == 0) ? 0 : g;
    if (eg != irqg) return 0;
    if (ns && !sec_disable) begin
      f = m_nsac[2*id +: 2];
      if (irqg == 0 && f < 2'd1) return 0;
      if (irqg == 1 && f < 2'd2) return 0;
    end
    return 1;
  endfunction

  // bus and stimulus tasks
  task automatic wr(input logic [7:0] a, input bit b, input bit s, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_byte = b; bus_secure = s; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
    m_write(a, b, s, d);
  endtask

  task automatic rd(input logic [7:0] a, input bit b, input bit s, output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_byte = b; bus_secure = s; bus_addr = a;
    #1 q = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input bit b, input bit s);
    logic [31:0] q;
    rd(a, b, s, q);
    chk(tag, q, m_read(a, b, s));
  endtask

  task automatic set_ppi(input logic [15:0] v);
    @(negedge clk);
    ppi_level = v;
    m_pend = m_pend | {v & ~m_lvl & m_edge, 16'h0};
    m_lvl = v;
    @(posedge clk); #1;
  endtask

  task automatic send_sgi(input int id, input int g, input bit ns);
    @(negedge clk);
    sgi_req = 1; sgi_id = 4'(id); sgi_grp = 2'(g); sgi_ns = ns;
    if (m_sgi_ok(id, g, ns)) m_pend[id] = 1'b1;
    @(posedge clk); #1;
    sgi_req = 0;
  endtask

  task automatic set_dis(input bit v);
    @(negedge clk);
    sec_disable = v;
  endtask

  function automatic logic [7:0] rand_addr();
    int k = int'($urandom % 22);
    if (k < 12) return 8'(k * 4);
    if (k < 20) return 8'(8'h40 + (k - 12) * 4);
    return (k == 20) ? 8'h30 : 8'h64;
  endfunction

  initial begin
    #(5ns * 150000);
    bad++; total++;
    $display("FAIL watchdog: got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    void'($urandom(32'd20240611));
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_byte = 0; bus_secure = 1;
    bus_addr = '0; bus_wdata = '0; sec_disable = 0; ppi_level = '0;
    sgi_req = 0; sgi_id = '0; sgi_grp = '0; sgi_ns = 0;
    m_grp = '0; m_en = '0; m_pend = '0; m_act = '0; m_mod = '0; m_nsac = '0;
    m_edge = '0; m_lvl = '0; m_sleep = 0;
    for (int i = 0; i < 32; i++) m_prio[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(8'h04, 0, 1, q); chk("R1 group", q, 32'h0);
    rd(8'h10, 0, 1, q); chk("R1 pend", q, 32'h0);
    rd(8'h20, 0, 1, q); chk("R1 cfg_lo", q, 32'hAAAA_AAAA);
    rd(8'h00, 0, 1, q); chk("R1 wake", q, 32'h0);
    rd(8'h5C, 0, 1, q); chk("R1 prio", q, 32'h0);

    // R8 wake register
    wr(8'h00, 0, 1, 32'hFFFF_FFFF);
    rd(8'h00, 0, 1, q); chk("R8 wake set", q, 32'h3);
    wr(8'h00, 0, 0, 32'h0);
    rd(8'h00, 0, 1, q); chk("R8 wake clear", q, 32'h0);

    // R2 access mask on bitmaps
    wr(8'h04, 0, 1, 32'h0000_FF00);
    wr(8'h08, 0, 0, 32'hFFFF_FFFF);
    rd(8'h08, 0, 1, q); chk("R2 ns set masked", q, 32'h0000_FF00);
    wr(8'h08, 0, 1, 32'h0001_0001);
    wr(8'h0C, 0, 0, 32'hFFFF_FFFF);
    rd(8'h0C, 0, 1, q); chk("R2 ns clear masked", q, 32'h0001_0001);
    rd(8'h08, 0, 0, q); chk("R2 ns read masked", q, 32'h0);

    // R3 banked registers
    wr(8'h04, 0, 0, 32'hFFFF_FFFF);
    rd(8'h04, 0, 1, q); chk("R3 ns group write ignored", q, 32'h0000_FF00);
    rd(8'h04, 0, 0, q); chk("R3 ns group raz", q, 32'h0);
    set_dis(1);
    wr(8'h28, 0, 1, 32'h1234);
    rd(8'h28, 0, 1, q); chk("R3 gmod raz when disabled", q, 32'h0);
    set_dis(0);
    rd(8'h28, 0, 1, q); chk("R3 gmod write ignored when disabled", q, 32'h0);

    // R4 non-secure priority view; R5 lane order
    wr(8'h48, 0, 1, 32'h4433_2211);
    rd(8'h48, 0, 0, q); chk("R4 ns prio view", q, 32'h8866_4422);
    wr(8'h48, 1, 0, 32'h40);
    rd(8'h48, 1, 1, q); chk("R4 ns prio store", q, 32'hA0);
    wr(8'h40, 1, 1, 32'h10);
    wr(8'h40, 1, 0, 32'hFF);
    rd(8'h40, 1, 1, q); chk("R4 group0 write ignored", q, 32'h10);
    rd(8'h40, 1, 0, q); chk("R4 group0 raz", q, 32'h0);
    wr(8'h5C, 0, 1, 32'hDDCC_BBAA);
    rd(8'h5F, 1, 1, q); chk("R5 byte msb lane", q, 32'hDD);
    rd(8'h5C, 1, 1, q); chk("R5 byte lsb lane", q, 32'hAA);

    // R7 configuration
    wr(8'h20, 0, 1, 32'h0);
    rd(8'h20, 0, 1, q); chk("R7 cfg_lo ignored", q, 32'hAAAA_AAAA);
    wr(8'h24, 0, 1, 32'h0000_0008);
    rd(8'h24, 0, 1, q); chk("R7 cfg_hi odd bit", q, 32'h0000_0008);

    // R6 live level; R9 edge latch; R13 timing
    set_ppi(16'h0001);
    rd(8'h10, 0, 1, q); chk("R6 level visible", q & 32'h0001_0000, 32'h0001_0000);
    set_ppi(16'h0000);
    rd(8'h10, 0, 1, q); chk("R6 level not latched", q & 32'h0001_0000, 32'h0);
    @(negedge clk);
    ppi_level = 16'h0002;
    bus_valid = 1; bus_write = 0; bus_byte = 0; bus_secure = 1; bus_addr = 8'h10;
    #1 chk("R13 before edge", bus_rdata & 32'h0002_0000, 32'h0);
    @(posedge clk); #1;
    chk("R13 after edge", bus_rdata & 32'h0002_0000, 32'h0002_0000);
    bus_valid = 0;
    m_pend[17] = 1'b1; m_lvl = 16'h0002;
    set_ppi(16'h0000);
    rd(8'h10, 0, 1, q); chk("R9 edge latched", q & 32'h0002_0000, 32'h0002_0000);
    set_ppi(16'h0000);
    wr(8'h14, 0, 1, 32'h0002_0000);
    rd(8'h10, 0, 1, q); chk("R9 unchanged level no set", q & 32'h0002_0000, 32'h0);

    // R10 SGI group resolution (SGI 3 group 0)
    send_sgi(3, 1, 0);
    rd(8'h10, 0, 1, q); chk("R10 g1s taken as g0", q & 32'h8, 32'h8);
    send_sgi(4, 2, 0);
    rd(8'h10, 0, 1, q); chk("R10 mismatch dropped", q & 32'h10, 32'h0);

    // R11 non-secure access field
    send_sgi(5, 0, 1);
    rd(8'h10, 0, 1, q); chk("R11 field0 g0 dropped", q & 32'h20, 32'h0);
    wr(8'h2C, 0, 1, 32'h0000_1400);   // SGI5 field=1, SGI6 field=1
    send_sgi(5, 0, 1);
    rd(8'h10, 0, 1, q); chk("R11 field1 g0 accepted", q & 32'h20, 32'h20);
    wr(8'h28, 0, 1, 32'h0000_0040);   // SGI6 secure group 1
    send_sgi(6, 1, 1);
    rd(8'h10, 0, 1, q); chk("R11 field1 g1s dropped", q & 32'h40, 32'h0);
    wr(8'h2C, 0, 1, 32'h0000_2400);
    send_sgi(6, 1, 1);
    rd(8'h10, 0, 1, q); chk("R11 field2 g1s accepted", q & 32'h40, 32'h40);

    // R12 unmapped and byte outside priority range
    wr(8'h30, 0, 1, 32'hFFFF_FFFF);
    rd(8'h30, 0, 1, q); chk("R12 unmapped raz", q, 32'h0);
    wr(8'h08, 1, 1, 32'hFF);
    rd(8'h08, 0, 1, q); chk("R12 byte write ignored", q, m_read(8'h08, 0, 1));
    rd(8'h04, 1, 1, q); chk("R12 byte read raz", q, 32'h0);

    // random traffic against the model (R2 R4 R6 R9 R10 R11)
    for (int it = 0; it < 3000; it++) begin
      int kind = int'($urandom % 10);
      bit s = 1'($urandom % 2);
      logic [7:0] a;
      bit b = ($urandom % 5) == 0;
      a = rand_addr();
      if (b) a = (($urandom % 2) != 0) ? 8'(8'h40 + $urandom % 32) : a;
      if (kind < 4)       wr(a, b, s, $urandom);
      else if (kind < 6)  set_ppi(16'($urandom));
      else if (kind < 8)  send_sgi(int'($urandom % 16), int'($urandom % 3), 1'($urandom % 2));
      else if (kind == 8) set_dis(1'(($urandom % 4) == 0));
      rd_chk("R2 random model", rand_addr(), 1'b0, 1'($urandom % 2));
      if (b) rd_chk("R4 random prio byte", 8'(8'h40 + $urandom % 32), 1'b1, s);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule